// File: doc/BRIEF.md
# Strap-Latched Boot Hold Controller

This block holds a device in a controlled boot state after the board releases its bus reset. While the bus reset is asserted it captures a set of board strap pins on every clock. The values captured at the last clock before release become the starting values of a small control and status register. From that register the block drives a configuration-retry output, which tells the configuration target logic to answer every configuration cycle with a retry. It also drives two core-reset outputs that keep two processor cores in reset.

Local firmware opens the device to the host by clearing the retry bit. A firmware watchdog can also release it. When the timeout strap enables the watchdog, a counter starts as reset ends. If the retry bit is still set when the counter reaches its terminal count, the counter clears the retry bit and the timer-enable bit together. A timer-enable bit that still reads 1 after release therefore shows that firmware did the release. Software releases each core by clearing its hold bit. An internal reset request puts both hold bits back to their strapped values.

The register port is a single word with no address. A write applies to every field at once. Bit 0 is the retry bit, bit 1 is the timer-enable bit, bits 2 and 3 are the hold bits for core 0 and core 1, and bit 4 reports the wide-bus strap.

Top module: `boot_hold_ctrl`

## Requirements
- R1: The straps are captured on every clock while `bus_rst_n` is low, and the last capture is kept. Strap changes after release have no effect on any bit, and this includes the defaults restored by `int_rst_req`.
- R2: Bit 0 (retry) comes out of reset equal to `strap_retry`, and `cfg_retry` always equals bit 0.
- R3: Bit 1 (timer enable) comes out of reset as 1 when `strap_tmr_dis_n` is high and as 0 when it is low. Software writes do not change it.
- R4: If bits 0 and 1 are both 1 at release, both bits read 0 after the LIMIT-th rising edge with `bus_rst_n` high and still read 1 after edge LIMIT-1. Here LIMIT = (CLK_HZ/1000)*TIMEOUT_MS. Bit 1 never falls unless bit 0 falls on the same edge, and a retry bit that is already 0 leaves bit 1 untouched.
- R5: If firmware clears bit 0 before expiry, bit 1 stays 1 from then on and the timer has no further effect.
- R6: With bit 1 at 0, bit 0 changes only through a software write.
- R7: Bits 2 and 3 (core 0 and core 1 hold) come out of reset as 1 when the matching bit of `strap_core_run_n` is low and as 0 when it is high. `core_rst` equals bits 3:2.
- R8: Writing 0 to a hold bit clears it, and writing 1 leaves it unchanged. A hold bit never sets except by reset or `int_rst_req`, which restores both hold bits to their captured defaults and takes precedence over a write on the same edge.
- R9: A write can only clear bit 0, never set it. A write that clears bit 0 on the same edge as timer expiry counts as a firmware release, so bit 1 stays 1.
- R10: Bit 4 reads 0 when `strap_wide_n` was captured low and 1 otherwise, and it stays stable until the next bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| bus_rst_n | input | 1 | Bus reset, active low, sampled synchronously |
| int_rst_req | input | 1 | Internal request to restore the core hold bits |
| strap_retry | input | 1 | Strap: high makes configuration cycles retry at boot |
| strap_tmr_dis_n | input | 1 | Strap: low disables the firmware watchdog |
| strap_core_run_n | input | 2 | Straps: a low bit holds the matching core in reset |
| strap_wide_n | input | 1 | Strap: low reports a wide (64-bit) bus |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DW | Register write data |
| rd_data | output | DW | Register read data |
| cfg_retry | output | 1 | Retry all configuration cycles |
| core_rst | output | 2 | Reset hold, one bit per core |

## Verification
All state sits in registers, and `rd_data` is a combinational view of those registers. A write or an `int_rst_req` pulse therefore shows on the outputs one rising edge later. Strap values captured during reset are visible on the first edge after release. Timer expiry lands exactly on the LIMIT-th edge after release. When the bench drives a stimulus, it queues the expected register word together with the absolute edge count at which that word must appear. A monitor compares each queued item shortly after its edge, and it checks both sides of the expiry boundary and the case where a write and expiry fall on the same edge.

// File: rtl/boot_hold_ctrl.sv
module boot_hold_ctrl #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned TIMEOUT_MS = 400,
  parameter int unsigned DW         = 8
) (
  input  logic          clk,
  input  logic          bus_rst_n,
  input  logic          int_rst_req,
  input  logic          strap_retry,
  input  logic          strap_tmr_dis_n,
  input  logic [1:0]    strap_core_run_n,
  input  logic          strap_wide_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          cfg_retry,
  output logic [1:0]    core_rst
);
  localparam int unsigned LIMIT = (CLK_HZ / 1000) * TIMEOUT_MS;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  logic          retry_q, tmr_en_q, wide_n_q;
  logic [1:0]    hold_q, hold_dflt_q;
  logic [CW-1:0] cnt_q;

  logic run, expire, fw_clr, unused_wr;
  assign run       = retry_q & tmr_en_q;
  assign expire    = run && (cnt_q == CW'(LIMIT - 1));
  assign fw_clr    = wr_en & ~wr_data[0];
  assign unused_wr = ^{wr_data[DW-1:4], wr_data[1]};

  always_ff @(posedge clk) begin
    if (!bus_rst_n) begin
      retry_q     <= strap_retry;
      tmr_en_q    <= strap_tmr_dis_n;
      hold_dflt_q <= ~strap_core_run_n;
      hold_q      <= ~strap_core_run_n;
      wide_n_q    <= strap_wide_n;
      cnt_q       <= '0;
    end else begin
      if (fw_clr) begin
        retry_q <= 1'b0;
      end else if (expire) begin
        retry_q  <= 1'b0;
        tmr_en_q <= 1'b0;
      end
      if (run) cnt_q <= cnt_q + 1'b1;
      if (int_rst_req)  hold_q <= hold_dflt_q;
      else if (wr_en)   hold_q <= hold_q & wr_data[3:2];
    end
  end

  assign rd_data   = DW'({wide_n_q, hold_q, tmr_en_q, retry_q});
  assign cfg_retry = retry_q;
  assign core_rst  = hold_q;
endmodule

module boot_hold_ctrl_chk (
  input logic       clk,
  input logic       bus_rst_n,
  input logic       int_rst_req,
  input logic       wr_en,
  input logic [4:0] rd_bits,
  input logic       cfg_retry,
  input logic [1:0] core_rst
);
  p_retry_out_r2: assert property (@(posedge clk) disable iff (!bus_rst_n)
    $past(bus_rst_n) |-> cfg_retry == rd_bits[0]);

  p_tmr_falls_with_retry_r4: assert property (@(posedge clk) disable iff (!bus_rst_n)
    ($past(bus_rst_n) && $fell(rd_bits[1])) |-> $fell(cfg_retry));

  p_tmr_no_rise_r3: assert property (@(posedge clk) disable iff (!bus_rst_n)
    $past(bus_rst_n) |-> !$rose(rd_bits[1]));

  p_no_auto_release_r6: assert property (@(posedge clk) disable iff (!bus_rst_n)
    ($past(bus_rst_n) && !$past(rd_bits[1]) && !$past(wr_en)) |-> $stable(cfg_retry));

  p_core_out_r7: assert property (@(posedge clk) disable iff (!bus_rst_n)
    $past(bus_rst_n) |-> core_rst == rd_bits[3:2]);

  p_hold_no_set_r8: assert property (@(posedge clk) disable iff (!bus_rst_n)
    ($past(bus_rst_n) && !$past(int_rst_req)) |-> (core_rst & ~$past(core_rst)) == 2'b00);

  p_retry_no_set_r9: assert property (@(posedge clk) disable iff (!bus_rst_n)
    $past(bus_rst_n) |-> !$rose(cfg_retry));

  p_wide_stable_r10: assert property (@(posedge clk) disable iff (!bus_rst_n)
    $past(bus_rst_n) |-> $stable(rd_bits[4]));
endmodule

bind boot_hold_ctrl boot_hold_ctrl_chk u_chk (
  .clk(clk), .bus_rst_n(bus_rst_n), .int_rst_req(int_rst_req), .wr_en(wr_en),
  .rd_bits(rd_data[4:0]), .cfg_retry(cfg_retry), .core_rst(core_rst)
);

// File: tb/tb_boot_hold_ctrl.sv
module tb_boot_hold_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HZ  = 1000;
  localparam int MS  = 40;
  localparam int LIM = (HZ / 1000) * MS;

  logic       clk = 1'b0;
  logic       bus_rst_n = 1'b0, int_rst_req = 1'b0;
  logic       strap_retry = 1'b0, strap_tmr_dis_n = 1'b0, strap_wide_n = 1'b0;
  logic [1:0] strap_core_run_n = 2'b00;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       cfg_retry;
  logic [1:0] core_rst;

  boot_hold_ctrl #(.CLK_HZ(HZ), .TIMEOUT_MS(MS), .DW(8)) dut (
    .clk(clk), .bus_rst_n(bus_rst_n), .int_rst_req(int_rst_req),
    .strap_retry(strap_retry), .strap_tmr_dis_n(strap_tmr_dis_n),
    .strap_core_run_n(strap_core_run_n), .strap_wide_n(strap_wide_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .cfg_retry(cfg_retry), .core_rst(core_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int        cyc = 0, errors = 0, checks = 0;
  int        due_q[$];
  logic [7:0] exp_q[$];
  string     tag_q[$];

  always @(posedge clk) begin
    cyc++;
    #1;
    for (int i = due_q.size() - 1; i >= 0; i--) begin
      if (due_q[i] == cyc) begin
        checks++;
        if (rd_data[4:0] !== exp_q[i][4:0] || cfg_retry !== exp_q[i][0] ||
            core_rst !== exp_q[i][3:2]) begin
          errors++;
          $display("FAIL %s: rd=%h retry=%b core=%b, expected rd=%h retry=%b core=%b",
                   tag_q[i], rd_data, cfg_retry, core_rst,
                   exp_q[i], exp_q[i][0], exp_q[i][3:2]);
        end
        due_q.delete(i); exp_q.delete(i); tag_q.delete(i);
      end
    end
  end

  task automatic expect_at(input int n, input logic [7:0] v, input string tag);
    due_q.push_back(cyc + n); exp_q.push_back(v); tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_with(input logic r, input logic td, input logic [1:0] cr, input logic w);
    @(negedge clk);
    strap_retry = r; strap_tmr_dis_n = td; strap_core_run_n = cr; strap_wide_n = w;
    bus_rst_n = 1'b0;
    tick(3);
    bus_rst_n = 1'b1;
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    // A: timer release, hold-bit writes, internal reset
    reset_with(1'b1, 1'b1, 2'b00, 1'b0);
    expect_at(1, 8'h0F, "R2 R3 R7 R10 defaults");
    strap_retry = 1'b0; strap_tmr_dis_n = 1'b0; strap_core_run_n = 2'b11; strap_wide_n = 1'b1;
    expect_at(LIM - 1, 8'h0F, "R4 R1 before expiry");
    expect_at(LIM, 8'h0C, "R4 expiry clears retry and timer bit");
    tick(LIM + 1);
    expect_at(1, 8'h08, "R8 clear core0 hold");
    write(8'hFB);
    expect_at(1, 8'h08, "R8 ones have no effect");
    write(8'hFF);
    expect_at(1, 8'h0C, "R8 R1 internal reset restores captured holds");
    int_rst_req = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    tick(1);
    int_rst_req = 1'b0; wr_en = 1'b0;
    expect_at(1, 8'h00, "R8 clear both holds");
    write(8'h00);

    // B: firmware release before expiry
    reset_with(1'b1, 1'b1, 2'b11, 1'b1);
    expect_at(1, 8'h13, "R2 R3 R10 defaults");
    tick(8);
    expect_at(1, 8'h12, "R5 firmware clear keeps timer bit");
    write(8'hFE);
    expect_at(LIM + 2, 8'h12, "R5 timer has no later effect");
    tick(LIM + 3);
    expect_at(1, 8'h12, "R9 write cannot set retry");
    write(8'hFF);

    // C: watchdog disabled
    reset_with(1'b1, 1'b0, 2'b01, 1'b1);
    expect_at(1, 8'h19, "R3 R7 defaults");
    expect_at(LIM + 5, 8'h19, "R6 no automatic release");
    tick(LIM + 6);

    // D: write clear on the expiry edge
    reset_with(1'b1, 1'b1, 2'b11, 1'b0);
    expect_at(1, 8'h03, "R2 R3 defaults");
    tick(LIM - 1);
    expect_at(1, 8'h02, "R9 same-edge clear is firmware release");
    write(8'hFE);

    // E: retry strapped off
    reset_with(1'b0, 1'b1, 2'b10, 1'b0);
    expect_at(1, 8'h06, "R2 R7 defaults");
    expect_at(LIM + 3, 8'h06, "R4 timer idle when retry clear");
    tick(LIM + 4);

    tick(2);
    if (due_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R1: %0d checks left pending, expected 0", due_q.size());
    end
    finish_run();
  end
endmodule